// File: doc/BRIEF.md
# Multi-Channel Interrupt Cause Aggregator

This block gathers completion events from eight storage channels. The channels are arranged as two host groups of four. Each channel produces two kinds of single-cycle pulse: a queue-done event and a legacy device interrupt.

Each group keeps its own cause register, which latches these pulses. Software acknowledges serviced bits by writing the complement of them, because a bit written as 0 is cleared and a bit written as 1 is left as it is. A read-only main cause word packs each channel's pair of bits into a fixed position. Channel positions skip one bit between the two groups. Nine additional level inputs feed fixed upper positions of the main cause word.

A main mask selects which main cause bits may raise the single interrupt output. The output is registered. Software reaches all of this through a small register port: a valid strobe, a write flag, an address and write data, with a registered read result.

Top module: `intr_cause_aggr`

## Requirements
- R1: A queue-done pulse on channel n sets bit (n mod 4) of its group cause register. Channels 0-3 use group 0 (address 0) and channels 4-7 use group 1 (address 1). The bit stays set until it is cleared.
- R2: A legacy device pulse on channel n sets bit (n mod 4)+8 of its group cause register.
- R3: A write to a group cause register clears each bit written as 0 and leaves each bit written as 1 unchanged. Writing 0 clears every pending bit.
- R4: When a pulse and a clearing write hit the same group bit in the same cycle, the bit ends up set.
- R5: The main cause word (address 2) carries channel n's queue-done bit at position 2n+(n>3 ? 1 : 0) and its device bit one position above. Bit 8 and bits 17-21 and 23 read 0.
- R6: Auxiliary input aux_evt_i[0] appears at main cause bit 22, and aux_evt_i[k] for k=1..8 appears at bit 23+k.
- R7: The main mask (address 3) is 0 after reset. Only bits 0-7, 9-16, 22 and 24-31 are writable; all other bits read 0.
- R8: irq_o is high in the cycle after any main cause bit and the matching mask bit are both 1, and low otherwise.
- R9: After reset, rd_data_o and irq_o are 0. A read request (valid with write low) loads rd_data_o at that clock edge, and rd_data_o holds that value until the next read.
- R10: A write to the main cause address has no effect on any cause bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| qdone_i | input | 8 | Per-channel queue-done pulses |
| dev_irq_i | input | 8 | Per-channel legacy device pulses |
| aux_evt_i | input | 9 | Auxiliary level events for the upper main cause bits |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 for write, 0 for read |
| reg_addr_i | input | 2 | 0/1 group cause, 2 main cause, 3 main mask |
| reg_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench builds the block with its default parameters: two groups of four channels, device bits at offset 8, and nine auxiliary events. With these values the group-boundary gap at main bit 8 and the highest channel position, bit 16, can both be reached by stimulus. Table vectors drive mixes of queue-done and device pulses across both groups and compare all three cause words. Directed tests then cover acknowledgement by writing a complement, a pulse that collides with a clearing write, the writable mask positions, and the interrupt latency.

// File: rtl/icag_pkg.sv
package icag_pkg;

    localparam int NUM_GROUPS   = 2;
    localparam int CH_PER_GROUP = 4;
    localparam int DEV_OFFSET   = 8;
    localparam int AUX_N        = 9;
    localparam int DATA_W       = 32;
    localparam int NUM_CH       = NUM_GROUPS * CH_PER_GROUP;
    localparam int GRP_W        = DEV_OFFSET + CH_PER_GROUP;
    localparam int ADDR_W       = $clog2(NUM_GROUPS + 2);

    typedef enum logic [ADDR_W-1:0] {
        SEL_GRP0 = 2'd0,
        SEL_GRP1 = 2'd1,
        SEL_MAIN = 2'd2,
        SEL_MASK = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } reg_req_t;

    // Main cause position of a channel's queue-done bit; one spare bit per group boundary.
    function automatic int chan_pos(input int n, input int cpg);
        return 2 * n + (n / cpg);
    endfunction

    // Auxiliary event positions: first at 22, the rest from 24 upward.
    function automatic int aux_pos(input int i);
        return (i == 0) ? 22 : 23 + i;
    endfunction

    // Mask bits that software may set.
    function automatic logic [DATA_W-1:0] writable_mask(input int nch, input int cpg, input int naux);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int n = 0; n < nch; n++) begin
            m[chan_pos(n, cpg)]     = 1'b1;
            m[chan_pos(n, cpg) + 1] = 1'b1;
        end
        for (int i = 0; i < naux; i++) m[aux_pos(i)] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/icag_group_cause.sv
module icag_group_cause #(
    parameter int CPG     = icag_pkg::CH_PER_GROUP,
    parameter int DEV_OFF = icag_pkg::DEV_OFFSET,
    parameter int DW      = icag_pkg::DATA_W,
    localparam int GW     = DEV_OFF + CPG
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [CPG-1:0] qdone_i,
    input  logic [CPG-1:0] dev_i,
    input  logic           wr_en_i,
    input  logic [DW-1:0]  wdata_i,
    output logic [GW-1:0]  cause_o
);
    logic [GW-1:0] set_vec;
    logic [GW-1:0] keep_vec;
    logic [GW-1:0] cause_q;

    always_comb begin
        set_vec = '0;
        for (int c = 0; c < CPG; c++) begin
            set_vec[c]           = qdone_i[c];
            set_vec[DEV_OFF + c] = dev_i[c];
        end
    end

    assign keep_vec = wr_en_i ? wdata_i[GW-1:0] : {GW{1'b1}};

    // Pulses are ORed in after the clear so a colliding event survives.
    always_ff @(posedge clk) begin
        if (rst) cause_q <= '0;
        else     cause_q <= (cause_q & keep_vec) | set_vec;
    end

    assign cause_o = cause_q;

    a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
        qdone_i[0] |=> cause_o[0]);

    a_r2_dev_sets: assert property (@(posedge clk) disable iff (rst)
        dev_i[CPG-1] |=> cause_o[DEV_OFF + CPG - 1]);

    a_r3_zero_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && wdata_i[GW-1:0] == '0 && qdone_i == '0 && dev_i == '0) |=> (cause_o == '0));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && qdone_i == '0 && dev_i == '0) |=> $stable(cause_o));

endmodule

// File: rtl/icag_main_map.sv
module icag_main_map #(
    parameter int NG      = icag_pkg::NUM_GROUPS,
    parameter int CPG     = icag_pkg::CH_PER_GROUP,
    parameter int DEV_OFF = icag_pkg::DEV_OFFSET,
    parameter int NAUX    = icag_pkg::AUX_N,
    parameter int DW      = icag_pkg::DATA_W,
    localparam int GW     = DEV_OFF + CPG,
    localparam int NCH    = NG * CPG
) (
    input  logic [NG-1:0][GW-1:0] grp_i,
    input  logic [NAUX-1:0]       aux_i,
    output logic [DW-1:0]         main_o
);
    logic [DW-1:0] chan_bits;
    logic [DW-1:0] aux_bits;

    always_comb begin
        chan_bits = '0;
        for (int n = 0; n < NCH; n++) begin
            chan_bits[icag_pkg::chan_pos(n, CPG)]     = grp_i[n / CPG][n % CPG];
            chan_bits[icag_pkg::chan_pos(n, CPG) + 1] = grp_i[n / CPG][DEV_OFF + (n % CPG)];
        end
    end

    always_comb begin
        aux_bits = '0;
        for (int i = 0; i < NAUX; i++) aux_bits[icag_pkg::aux_pos(i)] = aux_i[i];
    end

    assign main_o = chan_bits | aux_bits;

endmodule

// File: rtl/icag_mask_irq.sv
module icag_mask_irq #(
    parameter int DW             = icag_pkg::DATA_W,
    parameter logic [DW-1:0] WMASK = '1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [DW-1:0] cause_i,
    output logic [DW-1:0] mask_o,
    output logic          irq_o
);
    logic [DW-1:0] mask_q;
    logic          irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_en_i) mask_q <= wdata_i & WMASK;
            irq_q <= |(cause_i & mask_q);
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = irq_q;

    a_r8_irq_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_o == '0) |=> !irq_o);

    a_r8_irq_raise: assert property (@(posedge clk) disable iff (rst)
        ((cause_i & mask_o) != '0) |=> irq_o);

endmodule

// File: rtl/intr_cause_aggr.sv
module intr_cause_aggr #(
    parameter int NUM_GROUPS   = icag_pkg::NUM_GROUPS,
    parameter int CH_PER_GROUP = icag_pkg::CH_PER_GROUP,
    parameter int DEV_OFFSET   = icag_pkg::DEV_OFFSET,
    parameter int AUX_N        = icag_pkg::AUX_N,
    parameter int DATA_W       = icag_pkg::DATA_W,
    localparam int NUM_CH      = NUM_GROUPS * CH_PER_GROUP,
    localparam int GRP_W       = DEV_OFFSET + CH_PER_GROUP,
    localparam int ADDR_W      = $clog2(NUM_GROUPS + 2)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] qdone_i,
    input  logic [NUM_CH-1:0] dev_irq_i,
    input  logic [AUX_N-1:0]  aux_evt_i,
    input  logic              reg_valid_i,
    input  logic              reg_write_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import icag_pkg::*;

    localparam logic [DATA_W-1:0] WMASK = writable_mask(NUM_CH, CH_PER_GROUP, AUX_N);
    localparam int MAIN_ADDR = NUM_GROUPS;
    localparam int MASK_ADDR = NUM_GROUPS + 1;

    reg_req_t req;
    assign req = '{valid: reg_valid_i, write: reg_write_i, addr: reg_addr_i, wdata: reg_wdata_i};

    logic [NUM_GROUPS-1:0][GRP_W-1:0] grp_cause;
    logic [DATA_W-1:0] main_cause;
    logic [DATA_W-1:0] mask_val;
    logic [DATA_W-1:0] rd_next;
    logic [DATA_W-1:0] rd_q;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        icag_group_cause #(
            .CPG     (CH_PER_GROUP),
            .DEV_OFF (DEV_OFFSET),
            .DW      (DATA_W)
        ) u_grp (
            .clk     (clk),
            .rst     (rst),
            .qdone_i (qdone_i[g*CH_PER_GROUP +: CH_PER_GROUP]),
            .dev_i   (dev_irq_i[g*CH_PER_GROUP +: CH_PER_GROUP]),
            .wr_en_i (req.valid && req.write && int'(req.addr) == g),
            .wdata_i (req.wdata),
            .cause_o (grp_cause[g])
        );
    end

    icag_main_map #(
        .NG      (NUM_GROUPS),
        .CPG     (CH_PER_GROUP),
        .DEV_OFF (DEV_OFFSET),
        .NAUX    (AUX_N),
        .DW      (DATA_W)
    ) u_map (
        .grp_i  (grp_cause),
        .aux_i  (aux_evt_i),
        .main_o (main_cause)
    );

    icag_mask_irq #(
        .DW    (DATA_W),
        .WMASK (WMASK)
    ) u_mask (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (req.valid && req.write && int'(req.addr) == MASK_ADDR),
        .wdata_i (req.wdata),
        .cause_i (main_cause),
        .mask_o  (mask_val),
        .irq_o   (irq_o)
    );

    always_comb begin
        rd_next = '0;
        if (int'(req.addr) < NUM_GROUPS)       rd_next[GRP_W-1:0] = grp_cause[req.addr];
        else if (int'(req.addr) == MAIN_ADDR)  rd_next = main_cause;
        else                                   rd_next = mask_val;
    end

    always_ff @(posedge clk) begin
        if (rst)                         rd_q <= '0;
        else if (req.valid && !req.write) rd_q <= rd_next;
    end

    assign rd_data_o = rd_q;

    a_r9_read_holds: assert property (@(posedge clk) disable iff (rst)
        !(reg_valid_i && !reg_write_i) |=> $stable(rd_data_o));

endmodule

// File: tb/intr_cause_aggr_tb_top.sv
module intr_cause_aggr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  qdone_i;
    logic [7:0]  dev_irq_i;
    logic [8:0]  aux_evt_i;
    logic        reg_valid_i;
    logic        reg_write_i;
    logic [1:0]  reg_addr_i;
    logic [31:0] reg_wdata_i;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2 clk = ~clk;

    intr_cause_aggr dut_i (
        .clk (clk), .rst (rst),
        .qdone_i (qdone_i), .dev_irq_i (dev_irq_i), .aux_evt_i (aux_evt_i),
        .reg_valid_i (reg_valid_i), .reg_write_i (reg_write_i),
        .reg_addr_i (reg_addr_i), .reg_wdata_i (reg_wdata_i),
        .rd_data_o (rd_data_o), .irq_o (irq_o)
    );

    typedef struct packed {
        logic [7:0]  qd;
        logic [7:0]  dv;
        logic [31:0] g0;
        logic [31:0] g1;
        logic [31:0] mn;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h01, 8'h00, 32'h0000_0001, 32'h0000_0000, 32'h0000_0001},
        '{8'h10, 8'h00, 32'h0000_0000, 32'h0000_0001, 32'h0000_0200},
        '{8'h00, 8'h80, 32'h0000_0000, 32'h0000_0800, 32'h0001_0000},
        '{8'hFF, 8'hFF, 32'h0000_0F0F, 32'h0000_0F0F, 32'h0001_FEFF},
        '{8'h00, 8'h08, 32'h0000_0800, 32'h0000_0000, 32'h0000_0080},
        '{8'h20, 8'h04, 32'h0000_0400, 32'h0000_0002, 32'h0000_0820}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_valid_i = 1'b0; reg_write_i = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_valid_i = 1'b1; reg_write_i = 1'b0; reg_addr_i = a;
        @(negedge clk);
        reg_valid_i = 1'b0;
        d = rd_data_o;
    endtask

    task automatic pulse(input logic [7:0] qd, input logic [7:0] dv);
        @(negedge clk);
        qdone_i = qd; dev_irq_i = dv;
        @(negedge clk);
        qdone_i = '0; dev_irq_i = '0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        rst = 1'b1;
        qdone_i = '0; dev_irq_i = '0; aux_evt_i = '0;
        reg_valid_i = 1'b0; reg_write_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state of outputs
        chk("R9 rdata after reset", rd_data_o, 32'h0);
        chk("R9 irq after reset", {31'b0, irq_o}, 32'h0);
        // R7 mask is zero after reset
        rd(2'd3, d); chk("R7 mask reset", d, 32'h0);

        // Table walk: R1 R2 R5
        foreach (VECS[i]) begin
            wr(2'd0, 32'h0);
            wr(2'd1, 32'h0);
            pulse(VECS[i].qd, VECS[i].dv);
            rd(2'd0, d); chk("R1/R2 group0 cause", d, VECS[i].g0);
            rd(2'd1, d); chk("R1/R2 group1 cause", d, VECS[i].g1);
            rd(2'd2, d); chk("R5 main cause", d, VECS[i].mn);
        end

        // R3: acknowledge bits 0 and 8 by writing complement
        wr(2'd0, 32'h0); wr(2'd1, 32'h0);
        pulse(8'h0F, 8'h0F);
        wr(2'd0, ~32'h0000_0101);
        rd(2'd0, d); chk("R3 complement ack", d, 32'h0000_0E0E);
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R3 write zero clears", d, 32'h0);

        // R4: event and clearing write collide
        @(negedge clk);
        reg_valid_i = 1'b1; reg_write_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 32'h0;
        qdone_i = 8'h02;
        @(negedge clk);
        reg_valid_i = 1'b0; reg_write_i = 1'b0; qdone_i = '0;
        rd(2'd0, d); chk("R4 event wins over clear", d, 32'h0000_0002);

        // R10: write to main cause ignored
        wr(2'd2, 32'h0);
        rd(2'd2, d); chk("R10 main cause write ignored", d, 32'h0000_0004);
        rd(2'd0, d); chk("R10 group cause untouched", d, 32'h0000_0002);

        // R6: auxiliary positions
        aux_evt_i = 9'h003;
        rd(2'd2, d); chk("R6 aux 0 and 1", d, 32'h0140_0004);
        aux_evt_i = 9'h100;
        rd(2'd2, d); chk("R6 aux 8", d, 32'h8000_0004);
        aux_evt_i = '0;

        // R7: writable mask bits
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); chk("R7 writable mask bits", d, 32'hFF41_FEFF);

        // R8: interrupt generation
        wr(2'd3, 32'h0000_0001);
        @(negedge clk);
        chk("R8 irq off for unmasked pending", {31'b0, irq_o}, 32'h0);
        wr(2'd3, 32'h0000_0004);
        @(negedge clk);
        chk("R8 irq on masked pending", {31'b0, irq_o}, 32'h1);
        wr(2'd0, ~32'h0000_0002);
        @(negedge clk);
        chk("R8 irq drops after ack", {31'b0, irq_o}, 32'h0);
        aux_evt_i = 9'h001;
        wr(2'd3, 32'h0040_0000);
        @(negedge clk);
        chk("R8 irq on aux event", {31'b0, irq_o}, 32'h1);
        aux_evt_i = '0;

        // R9: read data holds without a read
        rd(2'd3, d);
        wr(2'd3, 32'h0);
        repeat (2) @(negedge clk);
        chk("R9 rdata holds", rd_data_o, 32'h0040_0000);

        finish_run();
    end

endmodule